// File: doc/BRIEF.md
# Microscaled Block Dequantizer

This block turns the integer result of one quantized block dot product into a normalized floating-point partial sum. Each block of weights and each block of activations carries an 8-bit power-of-two scale, stored as an unsigned exponent whose value is 2^(E-127). The dot-product unit delivers a sign and a 12-bit unnormalized magnitude with two fractional bits. The block applies both scales by adding their exponents. It finds the leading one of the magnitude and shifts the bits below it into place. The result is a compact 20-bit float: one sign bit, an 8-bit biased exponent (bias 127) and an 11-bit mantissa with an implicit leading one. A downstream accumulator sums these partial results across blocks. That accumulation is outside this block.

The datapath has no mantissa multiplier. It uses one exponent adder, a leading-one detector and a left shifter. Each result falls into one of four classes, held in an enumerated type and selected by a unique case. RC_ZERO is chosen when the magnitude is zero. RC_FLUSH is chosen when the exponent underflows. RC_SAT is chosen when the exponent overflows. RC_NORM is the ordinary normalized result. No state carries from one input to the next: each valid input is classified on its own and registered in one clock.

Top module: `mx_block_dequant`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and low otherwise.
- R2: `out_word` is laid out as follows: bit 19 is the sign, bits 18:11 are the biased exponent and bits 10:0 are the mantissa. Bit 19 always equals the `in_sign` that produced the word.
- R3: Magnitude bit j has weight 2^(j-2). If the leading one of `in_mag` is at bit p, the exponent field is `in_wexp + in_aexp + p - 129`.
- R4: The mantissa field holds the magnitude bits below bit p, moved up so that bit p-1 lands in bit 10. Vacated low bits are zero-filled. No rounding is applied.
- R5: A zero `in_mag` gives an exponent field and a mantissa field of all zeros.
- R6: If the computed exponent is 0 or negative, the result is flushed: exponent and mantissa are all zeros, and the sign is kept.
- R7: If the computed exponent is 255 or more, the result saturates: exponent 254 (0xFE) and mantissa 0x7FF. An exponent field of 255 never appears on the output.
- R8: While `in_valid` is low, `out_word` keeps its previous value.
- R9: During reset, `out_valid` and `out_word` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input strobe |
| in_wexp | input | 8 | Weight block scale exponent |
| in_aexp | input | 8 | Activation block scale exponent |
| in_sign | input | 1 | Sign of the dot product |
| in_mag | input | 12 | Unnormalized magnitude with two fractional bits |
| out_valid | output | 1 | Result strobe |
| out_word | output | 20 | Sign, 8-bit exponent, 11-bit mantissa |

## Verification
The bench goes after several corner cases, and each has a typical failure:
- Leading one at the extreme bit positions 0 and 11. An off-by-one in the leading-one detector or in the shift amount shifts the exponent by one or leaks the hidden bit into the mantissa.
- Exponents exactly at 0, 1, 254 and 255. A wrong comparison flushes a valid tiny result, or emits the reserved all-ones exponent instead of saturating.
- A zero magnitude and negative signs. A design that gets these wrong loses the sign or produces a nonzero exponent.
- Back-to-back strobes followed by idle cycles. These expose a pipeline that drops or repeats results, or lets the output word change while idle.

// File: rtl/mxdq_pkg.sv
package mxdq_pkg;

    typedef enum logic [1:0] {
        RC_ZERO  = 2'd0,
        RC_FLUSH = 2'd1,
        RC_SAT   = 2'd2,
        RC_NORM  = 2'd3
    } res_class_e;

endpackage

// File: rtl/mxdq_lod.sv
module mxdq_lod #(
    parameter int MAG_W = 12,
    parameter int POS_W = $clog2(MAG_W)
) (
    input  logic [MAG_W-1:0] vec,
    output logic             found,
    output logic [POS_W-1:0] pos
);

    always_comb begin
        found = 1'b0;
        pos   = '0;
        for (int i = 0; i < MAG_W; i++) begin
            if (vec[i]) begin
                found = 1'b1;
                pos   = POS_W'(i);
            end
        end
    end

    always_comb begin
        if (found === 1'b1) begin
            AST_LOD_TOP: assert (vec[pos] && ((vec >> pos) == MAG_W'(1))); // R3
        end
    end

endmodule

// File: rtl/mxdq_expadd.sv
module mxdq_expadd #(
    parameter int EXP_W  = 8,
    parameter int POS_W  = 4,
    parameter int FRAC_W = 2,
    parameter int SUM_W  = EXP_W + 3
) (
    input  logic [EXP_W-1:0] wexp,
    input  logic [EXP_W-1:0] aexp,
    input  logic [POS_W-1:0] pos,
    output logic [SUM_W-1:0] raw
);

    localparam int BIAS   = (2 ** (EXP_W - 1)) - 1;
    localparam int OFFSET = BIAS + FRAC_W;

    always_comb begin
        raw = SUM_W'(wexp) + SUM_W'(aexp) + SUM_W'(pos) - SUM_W'(OFFSET);
    end

endmodule

// File: rtl/mxdq_norm.sv
module mxdq_norm #(
    parameter int MAG_W  = 12,
    parameter int MANT_W = 11,
    parameter int POS_W  = $clog2(MAG_W)
) (
    input  logic [MAG_W-1:0]  mag,
    input  logic              found,
    input  logic [POS_W-1:0]  pos,
    output logic [MANT_W-1:0] mant
);

    logic [POS_W-1:0] shamt;
    logic [MAG_W-1:0] aligned;

    always_comb begin
        shamt   = POS_W'(MAG_W - 1) - pos;
        aligned = mag << shamt;
    end

    generate
        if (MANT_W == MAG_W - 1) begin : g_exact
            always_comb mant = aligned[MAG_W-2:0];
        end else if (MANT_W > MAG_W - 1) begin : g_pad
            always_comb mant = {aligned[MAG_W-2:0], {(MANT_W - MAG_W + 1){1'b0}}};
        end else begin : g_trunc
            always_comb mant = aligned[MAG_W-2 -: MANT_W];
        end
    endgenerate

    always_comb begin
        if (found === 1'b1) begin
            AST_HIDDEN_AT_TOP: assert (aligned[MAG_W-1]); // R4
        end
    end

endmodule

// File: rtl/mx_block_dequant.sv
module mx_block_dequant #(
    parameter int EXP_W  = 8,
    parameter int MAG_W  = 12,
    parameter int FRAC_W = 2,
    parameter int MANT_W = 11
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [EXP_W-1:0]              in_wexp,
    input  logic [EXP_W-1:0]              in_aexp,
    input  logic                          in_sign,
    input  logic [MAG_W-1:0]              in_mag,
    output logic                          out_valid,
    output logic [EXP_W+MANT_W:0]         out_word
);
    import mxdq_pkg::*;

    localparam int OUT_W = 1 + EXP_W + MANT_W;
    localparam int POS_W = $clog2(MAG_W);
    localparam int SUM_W = EXP_W + 3;
    localparam int EMAX  = (2 ** EXP_W) - 1;

    logic              lz_found;
    logic [POS_W-1:0]  lz_pos;
    logic [SUM_W-1:0]  exp_raw;
    logic [MANT_W-1:0] mant_n;
    res_class_e        cls;
    logic [OUT_W-1:0]  word_next;

    mxdq_lod #(.MAG_W(MAG_W), .POS_W(POS_W)) u_lod (
        .vec   (in_mag),
        .found (lz_found),
        .pos   (lz_pos)
    );

    mxdq_expadd #(.EXP_W(EXP_W), .POS_W(POS_W), .FRAC_W(FRAC_W), .SUM_W(SUM_W)) u_exp (
        .wexp (in_wexp),
        .aexp (in_aexp),
        .pos  (lz_pos),
        .raw  (exp_raw)
    );

    mxdq_norm #(.MAG_W(MAG_W), .MANT_W(MANT_W), .POS_W(POS_W)) u_norm (
        .mag   (in_mag),
        .found (lz_found),
        .pos   (lz_pos),
        .mant  (mant_n)
    );

    // Result classification
    always_comb begin
        if (!lz_found) begin
            cls = RC_ZERO;
        end else if (exp_raw[SUM_W-1] || (exp_raw == '0)) begin
            cls = RC_FLUSH;
        end else if (exp_raw >= SUM_W'(EMAX)) begin
            cls = RC_SAT;
        end else begin
            cls = RC_NORM;
        end
    end

    // Output word selection
    always_comb begin
        unique case (cls)
            RC_ZERO:  word_next = {in_sign, {(EXP_W + MANT_W){1'b0}}};
            RC_FLUSH: word_next = {in_sign, {(EXP_W + MANT_W){1'b0}}};
            RC_SAT:   word_next = {in_sign, EXP_W'(EMAX - 1), {MANT_W{1'b1}}};
            RC_NORM:  word_next = {in_sign, exp_raw[EXP_W-1:0], mant_n};
            default:  word_next = '0;
        endcase
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_word <= word_next;
            end
        end
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid)); // R1

    AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_word[OUT_W-1] == $past(in_sign)); // R2

    AST_ZERO_MAG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mag == '0) |=> out_word[OUT_W-2:0] == '0); // R5

    AST_NO_EXP_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_word[OUT_W-2 -: EXP_W] != {EXP_W{1'b1}}); // R7

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_word)); // R8

endmodule

// File: tb/tb_mx_block_dequant.sv
`timescale 1ns/1ps
module tb_mx_block_dequant;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_wexp = '0;
    logic [7:0]  in_aexp = '0;
    logic        in_sign = 1'b0;
    logic [11:0] in_mag = '0;
    logic        out_valid;
    logic [19:0] out_word;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    mx_block_dequant dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_wexp(in_wexp), .in_aexp(in_aexp), .in_sign(in_sign),
        .in_mag(in_mag), .out_valid(out_valid), .out_word(out_word)
    );

    function automatic logic [19:0] model(int ew, int ea, bit s, int mag);
        int p = -1;
        int e;
        int m;
        for (int j = 0; j < 12; j++) if (((mag >> j) & 1) == 1) p = j;
        if (p < 0) return {s, 19'd0};
        e = ew + ea - 127 + p - 2;
        if (e <= 0) return {s, 19'd0};
        if (e >= 255) return {s, 8'hFE, 11'h7FF};
        m = (mag << (11 - p)) & 'h7FF;
        return {s, 8'(e), 11'(m)};
    endfunction

    task automatic check(string tag, logic [19:0] act, logic [19:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(int ew, int ea, bit s, int mag, string tag);
        in_wexp = 8'(ew); in_aexp = 8'(ea); in_sign = s; in_mag = 12'(mag);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R1 valid", 20'(out_valid), 20'd1);
        check(tag, out_word, model(ew, ea, s, mag));
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R9 valid in reset", 20'(out_valid), 20'd0);
        check("R9 word in reset", out_word, 20'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", 20'(out_valid), 20'd0);
    endtask

    task automatic t_normal();
        send(127, 127, 0, 4, "R3 unity");               // 1.0 -> exp 127
        send(127, 127, 0, 12'hFFF, "R4 top bit all ones");
        send(130, 120, 1, 12'h5A3, "R2 R3 R4 negative mixed");
        send(100, 140, 0, 1, "R3 leading one at bit 0");
        send(127, 127, 0, 12'h800, "R4 leading one at bit 11");
        check("R3 exact exp 136", 20'(out_word[18:11]), 20'd136);
    endtask

    task automatic t_zero();
        send(150, 150, 1, 0, "R5 zero magnitude negative");
        send(10, 10, 0, 0, "R5 zero magnitude positive");
    endtask

    task automatic t_flush();
        send(60, 60, 1, 4, "R6 underflow flush");
        send(64, 63, 0, 4, "R6 exponent exactly 0");
        send(64, 64, 0, 4, "R6 exponent 1 kept");
        check("R6 exp 1 word", out_word, {1'b0, 8'd1, 11'd0});
    endtask

    task automatic t_saturate();
        send(191, 190, 0, 4, "R7 exponent 254 kept");
        send(192, 190, 1, 4, "R7 exponent 255 saturates");
        check("R7 saturation word", out_word, {1'b1, 8'hFE, 11'h7FF});
        send(255, 255, 0, 12'hFFF, "R7 far overflow");
    endtask

    task automatic t_hold();
        logic [19:0] prev;
        send(127, 128, 0, 12'h0C3, "R3 before idle");
        prev = out_word;
        in_wexp = 8'd3; in_aexp = 8'd9; in_mag = 12'h777; in_sign = 1'b1;
        @(negedge clk);
        check("R1 low when idle", 20'(out_valid), 20'd0);
        check("R8 word held", out_word, prev);
        @(negedge clk);
        check("R8 word held again", out_word, prev);
    endtask

    task automatic t_back_to_back();
        in_wexp = 8'd127; in_aexp = 8'd127; in_sign = 1'b0; in_mag = 12'h00C;
        in_valid = 1'b1;
        @(negedge clk);
        check("R1 first of pair", 20'(out_valid), 20'd1);
        check("R4 first of pair", out_word, model(127, 127, 0, 12'h00C));
        in_wexp = 8'd120; in_sign = 1'b1; in_mag = 12'h3FF;
        @(negedge clk);
        in_valid = 1'b0;
        check("R1 second of pair", 20'(out_valid), 20'd1);
        check("R4 second of pair", out_word, model(120, 127, 1, 12'h3FF));
        @(negedge clk);
        check("R1 drop after pair", 20'(out_valid), 20'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_normal();
        t_zero();
        t_flush();
        t_saturate();
        t_hold();
        t_back_to_back();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule